// File: doc/BRIEF.md
# Cycle-Count Tracking Frequency Multiplier

This block derives an output tick stream that runs at a fixed multiple of a slow reference, such as a power-line zero-cross signal, with no phase detector. A prescaler turns the system clock into a one-cycle base enable. A loadable divider counts those base enables and emits one output tick each time it reaches the current divisor.

The divisor is held in an up/down register. At every synchronized rising edge of the reference, the block compares the number of output ticks seen in the period just ended with a target count. If the output ran fast (too many ticks), the divisor steps up by one. If it ran slow, the divisor steps down by one. This one-step-per-period rate is the loop filter. The divisor is clamped to a window around its nominal value.

An optional phase-align input restarts the divider at each reference edge. The output cycles then start in step with the reference as well as matching its frequency.

Top module: `freq_track_mult`

## Requirements
- R1: After reset, `tick_out` is 0 and `divisor` equals `DIV_NOM`.
- R2: Away from alignment restarts, `tick_out` is a one-cycle pulse repeating every `SYS_PER_BASE * divisor` system clocks.
- R3: When exactly `TARGET` ticks fell in the last reference period, the divisor keeps its value.
- R4: When more than `TARGET` ticks fell in the last reference period, the divisor rises by one. When fewer fell, it falls by one. There is never more than one step per reference edge.
- R5: The divisor never leaves the range `DIV_MIN`..`DIV_MAX`. At a bound, a step toward the outside is dropped.
- R6: The first synchronized reference rising edge after reset only opens a measurement window and leaves the divisor unchanged.
- R7: With `phase_align_en` high, the prescaler and divider restart on each reference rising edge. `tick_out` is then high in the cycle after the third rising clock edge that follows the reference going high (two synchronizer stages plus one edge stage).
- R8: The per-period tick counter saturates at `2**CNT_W-1`, where `CNT_W = $clog2(4*TARGET)+1`. A very long reference period therefore still reads as "too many ticks" and raises the divisor.
- R9: The divisor changes only on the clock edge that acts on a synchronized reference rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference (zero-cross) input |
| phase_align_en | input | 1 | Restart divider on each reference rising edge |
| tick_out | output | 1 | One-cycle output tick |
| divisor | output | DIV_W | Current divider reload value |

## Verification
The assertions check four things on every cycle:
- the divisor stays inside its clamp window;
- it moves by at most one per change;
- it holds steady except after a synchronized reference edge;
- an aligned reference edge is always followed by a tick.

The bench scenarios show the rest. They show the tick spacing at several divisor values and the direction of the servo for short and long reference periods. They also show saturation at both clamps, that an exact period is left alone, the ignored arming edge, and that the per-period counter does not wrap across a long gap.

// File: rtl/freq_track_mult.sv
module freq_track_mult #(
  parameter int SYS_PER_BASE = 30,
  parameter int DIV_W        = 11,
  parameter int DIV_NOM      = 1000,
  parameter int DIV_MIN      = 900,
  parameter int DIV_MAX      = 1100,
  parameter int TARGET       = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             phase_align_en,
  output logic             tick_out,
  output logic [DIV_W-1:0] divisor
);
  localparam int PRE_W = (SYS_PER_BASE > 1) ? $clog2(SYS_PER_BASE) : 1;
  localparam int CNT_W = $clog2(4 * TARGET) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_TGT = CNT_W'(TARGET);
  localparam logic [PRE_W-1:0] PRE_END = PRE_W'(SYS_PER_BASE - 1);

  logic [2:0]       ref_sr;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] cyc_cnt;
  logic             armed;

  wire ref_rise  = ref_sr[1] & ~ref_sr[2];
  wire align     = ref_rise & phase_align_en;
  wire base_tick = (pre_cnt == PRE_END);
  wire wrap      = base_tick && (div_cnt == divisor - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_sr <= '0;
    else        ref_sr <= {ref_sr[1:0], ref_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      div_cnt  <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= wrap | align;
      if (align) begin
        pre_cnt <= '0;
        div_cnt <= '0;
      end else begin
        pre_cnt <= base_tick ? '0 : pre_cnt + PRE_W'(1);
        if (base_tick) div_cnt <= wrap ? '0 : div_cnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      armed   <= 1'b0;
      divisor <= DIV_W'(DIV_NOM);
    end else if (ref_rise) begin
      armed   <= 1'b1;
      cyc_cnt <= tick_out ? CNT_W'(1) : '0;
      if (armed) begin
        if (cyc_cnt > CNT_TGT && divisor < DIV_W'(DIV_MAX))
          divisor <= divisor + DIV_W'(1);
        else if (cyc_cnt < CNT_TGT && divisor > DIV_W'(DIV_MIN))
          divisor <= divisor - DIV_W'(1);
      end
    end else if (tick_out && cyc_cnt != CNT_TOP) begin
      cyc_cnt <= cyc_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/freq_track_mult_sva.sv
module freq_track_mult_sva #(
  parameter int DIV_W   = 11,
  parameter int DIV_MIN = 900,
  parameter int DIV_MAX = 1100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_rise,
  input logic             phase_align_en,
  input logic             tick_out,
  input logic [DIV_W-1:0] divisor
);
  p_div_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    divisor >= DIV_W'(DIV_MIN) && divisor <= DIV_W'(DIV_MAX));

  p_div_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != $past(divisor)) |->
      (divisor == $past(divisor) + DIV_W'(1)) || (divisor == $past(divisor) - DIV_W'(1)));

  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rise |=> $stable(divisor));

  p_align_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && phase_align_en) |=> tick_out);
endmodule

bind freq_track_mult freq_track_mult_sva #(
  .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
) u_sva (
  .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise),
  .phase_align_en(phase_align_en), .tick_out(tick_out), .divisor(divisor)
);

// File: tb/freq_track_mult_tb.sv
`timescale 1ns/1ps
module freq_track_mult_tb;
  localparam int BASE = 2, W = 6, NOM = 20, MINV = 18, MAXV = 22, TGT = 4;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, align_en = 1'b0;
  logic tick_out;
  logic [W-1:0] divisor;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  freq_track_mult #(.SYS_PER_BASE(BASE), .DIV_W(W), .DIV_NOM(NOM),
    .DIV_MIN(MINV), .DIV_MAX(MAXV), .TARGET(TGT)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .phase_align_en(align_en),
    .tick_out(tick_out), .divisor(divisor));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset(input logic al);
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0; align_en = al;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one reference period; returns divisor seen after the edge has acted
  task automatic ref_period(input int per, output int div_after, output int tick_at3);
    ref_in = 1'b1;
    repeat (3) @(negedge clk);
    tick_at3 = int'(tick_out);
    div_after = int'(divisor);
    repeat (per / 2 - 3) @(negedge clk);
    ref_in = 1'b0;
    repeat (per - per / 2) @(negedge clk);
  endtask

  task automatic spacing(input string req, input int exp_div);
    int t0, gap;
    int d0 = int'(divisor);
    while (!tick_out) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(req, int'(tick_out), 0);
      gap = 1;
      while (!tick_out) begin @(negedge clk); gap++; end
      check(req, gap, BASE * exp_div);
    end
    check("R9", int'(divisor), d0);
  endtask

  initial begin
    int d, t, exp;
    do_reset(1'b0);
    check("R1", int'(tick_out), 0);
    check("R1", int'(divisor), NOM);
    spacing("R2", NOM);

    // short reference period -> output slow -> divisor falls and clamps
    do_reset(1'b0);
    ref_period(80, d, t);
    check("R6", d, NOM);
    exp = NOM;
    for (int i = 0; i < 4; i++) begin
      ref_period(80, d, t);
      exp = (exp > MINV) ? exp - 1 : exp;
      check(i < 2 ? "R4" : "R5", d, exp);
    end
    spacing("R2", MINV);

    // long reference period -> output fast -> divisor rises and clamps
    do_reset(1'b0);
    ref_period(320, d, t);
    check("R6", d, NOM);
    exp = NOM;
    for (int i = 0; i < 4; i++) begin
      ref_period(320, d, t);
      exp = (exp < MAXV) ? exp + 1 : exp;
      check(i < 2 ? "R4" : "R5", d, exp);
    end
    spacing("R2", MAXV);

    // aligned, exact period -> count equals target -> held
    do_reset(1'b1);
    for (int i = 0; i < 5; i++) begin
      ref_period(BASE * NOM * TGT, d, t);
      check("R7", t, 1);
      check(i == 0 ? "R6" : "R3", d, NOM);
    end

    // very long gap: counter must saturate rather than wrap
    do_reset(1'b0);
    ref_period(1400, d, t);
    ref_period(80, d, t);
    check("R8", d, NOM + 1);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule